// File: doc/BRIEF.md
# Shared Two-Port Memory with Collision Arbitration

This block is a 2048 x 8 memory that two requesters, a left port and a right port, reach independently and in the same clock cycle. Each port has an enable, a write strobe, an address, write data and registered read data. When both enabled ports name the same word, the block gives that word to the port that was there first and tells the other one through an active-low busy output. The losing port's writes are discarded. Its read data is frozen so that a write from the owner cannot change a value the loser is still reading.

A build parameter turns the block into a follower. In that mode it does no arbitration of its own. Each port instead takes a busy input, which a neighbouring arbitrating instance would drive, and that input inhibits the port's writes. This lets several instances be placed side by side to make a wider data word.

Top module: `dual_port_arb_ram`

## Requirements
- R1: Each port has an enable (1 = active) and a write strobe (1 = write). Any of the 2048 words can be accessed. A write stores the data at the clock edge while enable and strobe are both 1. The read data is registered: it shows the addressed word one edge after an enabled cycle, and it shows the word's contents from before any write made in that same cycle. While the enable is 0, the read data holds its value.
- R2: A collision is a cycle in which both enables are 1 and the two addresses are equal. The busy outputs are 0 only in the cycle after a collision. Colliding reads return correct data on both ports.
- R3: If one port was already enabled on the address, and the other port newly arrives on it (its enable rises, or its address changes onto that word), the port that was already there owns the word. The newcomer's busy output goes to 0 at the edge that ends the first colliding cycle. The two busy outputs are never 0 at the same time.
- R4: If both ports arrive on the same word in the same cycle, the left port owns it and the right port gets busy.
- R5: Busy returns to 1 at the edge after the first cycle in which the addresses differ or either enable is 0.
- R6: A write from the losing port is dropped, not deferred. This applies from the first colliding cycle onward, so the word keeps the owner's data or its earlier contents.
- R7: While a port keeps losing with an unchanged address, enable and strobe, its read data stays frozen, even if the owner writes the word. The read data is refreshed when the losing port re-arrives on the word (for example by changing its address and coming back) or toggles its strobe.
- R8: The owning port reads and writes normally during a collision. Toggling its own strobe does not move ownership.
- R9: With SLAVE_MODE=1, both busy outputs stay at 1. A port's write is suppressed in any cycle where that port's busy input is 0. Reads work normally whatever the busy inputs are.
- R10: Synchronous reset sets both busy outputs to 1 and both read data outputs to 0, and forgets which port owned a word.
- R11: With SLAVE_MODE=1, if both ports write the same word in the same cycle with their busy inputs at 1, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Left port enable |
| a_we | input | 1 | Left port write strobe |
| a_addr | input | ADDR_W | Left port word address |
| a_wdata | input | DATA_W | Left port write data |
| a_busy_in_n | input | 1 | Left busy input, active low (follower mode only) |
| a_rdata | output | DATA_W | Left port registered read data |
| a_busy_n | output | 1 | Left busy flag, active low |
| b_en | input | 1 | Right port enable |
| b_we | input | 1 | Right port write strobe |
| b_addr | input | ADDR_W | Right port word address |
| b_wdata | input | DATA_W | Right port write data |
| b_busy_in_n | input | 1 | Right busy input, active low (follower mode only) |
| b_rdata | output | DATA_W | Right port registered read data |
| b_busy_n | output | 1 | Right busy flag, active low |

## Verification
The hardest state to reach is a losing port whose read data must stay frozen while the owner overwrites the word. The stimulus then has to make the loser leave the address and come back, so that its read data picks up the new contents and ownership stays where it was. Directed sequences build this state step by step. They first park one port on a word, bring the other onto it, write from the owner and toggle the owner's strobe. Only then does the loser move away and return. A long random phase confines both ports to four addresses, so arrivals in the same cycle, staggered arrivals and mid-collision strobe toggles occur many times, with every cycle compared against the bench model.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Ownership decision for a colliding cycle.
  function automatic owner_e pick_owner(input logic left_new, input logic right_new,
                                        input owner_e held);
    owner_e res;
    if (left_new && !right_new)       res = OWN_RIGHT;  // right was there first
    else if (right_new && !left_new)  res = OWN_LEFT;   // left was there first
    else if (left_new && right_new)   res = OWN_LEFT;   // same-cycle tie
    else if (held == OWN_NONE)        res = OWN_LEFT;
    else                              res = held;
    return res;
  endfunction

endpackage

// File: rtl/dpa_req_tracker.sv
module dpa_req_tracker #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              fresh,
  output logic              refresh
);

  logic              en_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      we_q   <= we;
      addr_q <= addr;
    end
  end

  // A request is new when the enable rises or the address moves.
  assign fresh   = en && (!en_q || (addr != addr_q));
  // Read data is re-sampled on a new request or a strobe toggle.
  assign refresh = fresh || (en && (we != we_q));

endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter bit SLAVE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_busy_in_n,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_busy_in_n,
  output logic              a_wr,
  output logic              b_wr,
  output logic              a_hold,
  output logic              b_hold,
  output logic              a_busy_n,
  output logic              b_busy_n
);

  generate
    if (SLAVE_MODE) begin : g_follow
      logic unused_follow;
      assign unused_follow = ^{clk, a_addr, b_addr};
      assign a_wr     = !rst && a_en && a_we && a_busy_in_n;
      assign b_wr     = !rst && b_en && b_we && b_busy_in_n;
      assign a_hold   = 1'b0;
      assign b_hold   = 1'b0;
      assign a_busy_n = 1'b1;
      assign b_busy_n = 1'b1;
    end else begin : g_lead
      logic   unused_busy_in;
      logic   a_fresh, a_refresh, b_fresh, b_refresh;
      logic   clash;
      logic   a_lose, b_lose;
      owner_e owner_q, owner_nxt;
      logic   a_busy_q, b_busy_q;

      assign unused_busy_in = ^{a_busy_in_n, b_busy_in_n};

      dpa_req_tracker #(.ADDR_W(ADDR_W)) u_trk_a (
        .clk(clk), .rst(rst), .en(a_en), .we(a_we), .addr(a_addr),
        .fresh(a_fresh), .refresh(a_refresh)
      );
      dpa_req_tracker #(.ADDR_W(ADDR_W)) u_trk_b (
        .clk(clk), .rst(rst), .en(b_en), .we(b_we), .addr(b_addr),
        .fresh(b_fresh), .refresh(b_refresh)
      );

      assign clash = a_en && b_en && (a_addr == b_addr);

      always_comb begin
        if (clash) owner_nxt = pick_owner(a_fresh, b_fresh, owner_q);
        else       owner_nxt = OWN_NONE;
      end

      assign a_lose = clash && (owner_nxt == OWN_RIGHT);
      assign b_lose = clash && (owner_nxt == OWN_LEFT);

      always_ff @(posedge clk) begin
        if (rst) begin
          owner_q  <= OWN_NONE;
          a_busy_q <= 1'b0;
          b_busy_q <= 1'b0;
        end else begin
          owner_q  <= owner_nxt;
          a_busy_q <= a_lose;
          b_busy_q <= b_lose;
        end
      end

      assign a_wr     = !rst && a_en && a_we && !a_lose;
      assign b_wr     = !rst && b_en && b_we && !b_lose;
      assign a_hold   = a_lose && !a_refresh;
      assign b_hold   = b_lose && !b_refresh;
      assign a_busy_n = !a_busy_q;
      assign b_busy_n = !b_busy_q;
    end
  endgenerate

endmodule

// File: rtl/dpa_mem.sv
module dpa_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Arbitration keeps the two writes on distinct words; when it is
  // bypassed (follower mode) the left write is applied last and wins.
  always_ff @(posedge clk) begin
    if (b_wr) store[b_addr] <= b_wdata;
    if (a_wr) store[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= store[a_addr];
      if (b_rd) b_rdata <= store[b_addr];
    end
  end

endmodule

// File: rtl/dual_port_arb_ram.sv
module dual_port_arb_ram #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter bit SLAVE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_busy_in_n,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_busy_n,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_busy_in_n,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_busy_n
);

  logic a_wr, b_wr, a_hold, b_hold;

  dpa_arbiter #(.ADDR_W(ADDR_W), .SLAVE_MODE(SLAVE_MODE)) u_arb (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_busy_in_n(a_busy_in_n),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_busy_in_n(b_busy_in_n),
    .a_wr(a_wr), .b_wr(b_wr), .a_hold(a_hold), .b_hold(b_hold),
    .a_busy_n(a_busy_n), .b_busy_n(b_busy_n)
  );

  dpa_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_rd(a_en && !a_hold), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr(b_wr), .b_rd(b_en && !b_hold), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter bit SLAVE_MODE = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              a_en,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_busy_n,
  input logic              b_en,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_busy_n
);

  generate
    if (SLAVE_MODE) begin : g_follow_chk
      AST_FOLLOW_BUSY_IDLE: assert property (@(posedge clk) disable iff (rst) a_busy_n && b_busy_n); // R9
    end else begin : g_lead_chk
      AST_BUSY_ONLY_AFTER_CLASH: assert property (@(posedge clk) disable iff (rst)
        (!a_busy_n || !b_busy_n) |-> $past(a_en && b_en && (a_addr == b_addr))); // R2
      AST_ONE_LOSER: assert property (@(posedge clk) disable iff (rst)
        !(!a_busy_n && !b_busy_n)); // R3
      AST_EARLIER_WINS: assert property (@(posedge clk) disable iff (rst)
        (a_en && b_en && (a_addr == b_addr) && $past(a_en) && ($past(a_addr) == a_addr) && !$past(b_en))
        |=> (!b_busy_n && a_busy_n)); // R3
      AST_TIE_TO_LEFT: assert property (@(posedge clk) disable iff (rst)
        (a_en && b_en && (a_addr == b_addr) && !$past(a_en) && !$past(b_en))
        |=> (a_busy_n && !b_busy_n)); // R4
      AST_RELEASE_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        !(a_en && b_en && (a_addr == b_addr)) |=> (a_busy_n && b_busy_n)); // R5
      AST_LOSER_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!b_busy_n && a_en && b_en && $stable(a_en) && $stable(b_en) && $stable(a_addr)
         && $stable(b_addr) && $stable(b_we)) |=> $stable(b_rdata)); // R7
    end
  endgenerate

  logic unused_chk;
  assign unused_chk = a_we;

endmodule

bind dual_port_arb_ram dpa_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLAVE_MODE(SLAVE_MODE)) u_chk (
  .clk(clk), .rst(rst),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_rdata(a_rdata), .a_busy_n(a_busy_n),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_rdata(b_rdata), .b_busy_n(b_busy_n)
);

// File: tb/dual_port_arb_ram_test.sv
module dual_port_arb_ram_test;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic sa_bin = 1'b1, sb_bin = 1'b1;

  logic [DW-1:0] m_ard, m_brd, s_ard, s_brd;
  logic m_abusy, m_bbusy, s_abusy, s_bbusy;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dual_port_arb_ram #(.ADDR_W(AW), .DATA_W(DW), .SLAVE_MODE(1'b0)) uut (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_busy_in_n(1'b1),
    .a_rdata(m_ard), .a_busy_n(m_abusy),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_busy_in_n(1'b1),
    .b_rdata(m_brd), .b_busy_n(m_bbusy)
  );

  dual_port_arb_ram #(.ADDR_W(AW), .DATA_W(DW), .SLAVE_MODE(1'b1)) uut_follow (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_busy_in_n(sa_bin),
    .a_rdata(s_ard), .a_busy_n(s_abusy),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_busy_in_n(sb_bin),
    .b_rdata(s_brd), .b_busy_n(s_bbusy)
  );

  // ---------------- behavioural reference ----------------
  int ref_mem [WORDS];
  int ref_smem [WORDS];
  int r_ard, r_brd, r_sard, r_sbrd;
  int r_abusy, r_bbusy;
  int p_aen, p_awe, p_aaddr, p_ben, p_bwe, p_baddr;
  int owner;  // 0 none, 1 left, 2 right

  function automatic logic [7:0] iv(input int x);
    return x[7:0] ^ 8'h5A;
  endfunction

  task automatic model_edge();
    int clash, an, bn, ar, br, al, bl;
    if (rst) begin
      r_ard = 0; r_brd = 0; r_sard = 0; r_sbrd = 0;
      r_abusy = 1; r_bbusy = 1; owner = 0;
      p_aen = 0; p_awe = 0; p_aaddr = 0; p_ben = 0; p_bwe = 0; p_baddr = 0;
      return;
    end
    clash = (a_en && b_en && a_addr == b_addr) ? 1 : 0;
    an = (a_en && (p_aen == 0 || p_aaddr != int'(a_addr))) ? 1 : 0;
    bn = (b_en && (p_ben == 0 || p_baddr != int'(b_addr))) ? 1 : 0;
    ar = (an != 0 || (a_en && p_awe != int'(a_we))) ? 1 : 0;
    br = (bn != 0 || (b_en && p_bwe != int'(b_we))) ? 1 : 0;
    if (clash == 0) owner = 0;
    else if (an != 0 && bn == 0) owner = 2;
    else if (an != 0 || bn != 0 || owner == 0) owner = 1;
    al = (clash != 0 && owner == 2) ? 1 : 0;
    bl = (clash != 0 && owner == 1) ? 1 : 0;
    // follower instance: reads first, then writes, left last
    if (a_en) r_sard = ref_smem[a_addr];
    if (b_en) r_sbrd = ref_smem[b_addr];
    if (b_en && b_we && sb_bin) ref_smem[b_addr] = b_wdata;
    if (a_en && a_we && sa_bin) ref_smem[a_addr] = a_wdata;
    // arbitrating instance
    if (a_en && !(al != 0 && ar == 0)) r_ard = ref_mem[a_addr];
    if (b_en && !(bl != 0 && br == 0)) r_brd = ref_mem[b_addr];
    if (b_en && b_we && bl == 0) ref_mem[b_addr] = b_wdata;
    if (a_en && a_we && al == 0) ref_mem[a_addr] = a_wdata;
    r_abusy = al != 0 ? 0 : 1;
    r_bbusy = bl != 0 ? 0 : 1;
    p_aen = a_en; p_awe = a_we; p_aaddr = a_addr;
    p_ben = b_en; p_bwe = b_we; p_baddr = b_addr;
  endtask

  task automatic cmp(input string tag, input int act, input int exp);
    if (exp < 0) return;  // word not yet known
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cycles++;
    cmp("R1 left rdata", m_ard, r_ard);
    cmp("R1 right rdata", m_brd, r_brd);
    cmp("R3 left busy", m_abusy, r_abusy);
    cmp("R3 right busy", m_bbusy, r_bbusy);
    cmp("R9 follower left rdata", s_ard, r_sard);
    cmp("R9 follower right rdata", s_brd, r_sbrd);
    cmp("R9 follower left busy", s_abusy, 1);
    cmp("R9 follower right busy", s_bbusy, 1);
  endtask

  task automatic drv(input logic ae, input logic aw, input int aa, input int ad,
                     input logic be, input logic bw, input int ba, input int bd);
    a_en = ae; a_we = aw; a_addr = aa[AW-1:0]; a_wdata = ad[DW-1:0];
    b_en = be; b_we = bw; b_addr = ba[AW-1:0]; b_wdata = bd[DW-1:0];
  endtask

  task automatic idle();
    drv(0, 0, 0, 0, 0, 0, 0, 0);
    cyc();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      ref_mem[i] = -1;
      ref_smem[i] = -1;
    end
    @(negedge clk);
    rst = 1'b1;
    repeat (3) cyc();
    rst = 1'b0;
    // R10 reset state
    cmp("R10 left busy after reset", m_abusy, 1);
    cmp("R10 right busy after reset", m_bbusy, 1);
    cmp("R10 left rdata after reset", m_ard, 0);
    cmp("R10 right rdata after reset", m_brd, 0);

    // fill every word: value = low address byte xor 5A
    for (int i = 0; i < WORDS / 2; i++) begin
      drv(1, 1, i, iv(i), 1, 1, i + WORDS / 2, iv(i + WORDS / 2));
      cyc();
    end
    idle();

    // R1: top word write, neighbour read, no collision
    drv(1, 1, 12'h7FF, 8'hC3, 1, 0, 12'h7FE, 0); cyc();
    cmp("R1 right reads 7FE", m_brd, iv(12'h7FE));
    cmp("R2 no busy without clash", m_bbusy, 1);
    drv(1, 0, 12'h7FF, 0, 0, 0, 0, 0); cyc();
    cmp("R1 left reads back 7FF", m_ard, 8'hC3);
    idle();
    cmp("R1 rdata holds while disabled", m_ard, 8'hC3);

    // R3/R6/R5: left parked first, right arrives and tries to write
    drv(1, 0, 12'h100, 0, 0, 0, 0, 0); cyc();
    drv(1, 0, 12'h100, 0, 1, 0, 12'h100, 0); cyc();
    cmp("R3 newcomer right busy", m_bbusy, 0);
    cmp("R3 owner left not busy", m_abusy, 1);
    cmp("R2 colliding read right", m_brd, iv(12'h100));
    cmp("R2 colliding read left", m_ard, iv(12'h100));
    cmp("R9 follower busy idle in clash", s_bbusy, 1);
    drv(1, 0, 12'h100, 0, 1, 1, 12'h100, 8'hEE); cyc();
    cmp("R6 loser still busy while writing", m_bbusy, 0);
    drv(0, 0, 0, 0, 1, 0, 12'h100, 0); cyc();
    cmp("R5 busy released when left disables", m_bbusy, 1);
    drv(1, 0, 12'h100, 0, 0, 0, 0, 0); cyc();
    cmp("R6 losing write dropped", m_ard, iv(12'h100));
    idle();

    // R7/R8: owner writes while loser reads
    drv(1, 0, 12'h200, 0, 0, 0, 0, 0); cyc();
    drv(1, 0, 12'h200, 0, 1, 0, 12'h200, 0); cyc();
    cmp("R7 loser initial read", m_brd, iv(12'h200));
    drv(1, 1, 12'h200, 8'h33, 1, 0, 12'h200, 0); cyc();
    drv(1, 0, 12'h200, 0, 1, 0, 12'h200, 0); cyc();
    cmp("R8 owner strobe toggle keeps ownership", m_bbusy, 0);
    cmp("R8 owner reads own write", m_ard, 8'h33);
    cmp("R7 loser rdata frozen", m_brd, iv(12'h200));
    cyc();
    cmp("R7 loser rdata still frozen", m_brd, iv(12'h200));
    drv(1, 0, 12'h200, 0, 1, 0, 12'h201, 0); cyc();
    cmp("R5 busy released on address miss", m_bbusy, 1);
    cmp("R1 right reads 201", m_brd, iv(12'h201));
    drv(1, 0, 12'h200, 0, 1, 0, 12'h200, 0); cyc();
    cmp("R7 loser refreshed on return", m_brd, 8'h33);
    cmp("R3 returning right loses again", m_bbusy, 0);
    idle();

    // R4 tie, R11 follower same-word writes
    drv(1, 0, 12'h300, 0, 1, 0, 12'h300, 0); cyc();
    cmp("R4 tie left not busy", m_abusy, 1);
    cmp("R4 tie right busy", m_bbusy, 0);
    idle();
    drv(1, 1, 12'h301, 8'h77, 1, 1, 12'h301, 8'h88); cyc();
    drv(0, 0, 0, 0, 1, 0, 12'h301, 0); cyc();
    cmp("R4 tie write keeps left data", m_brd, 8'h77);
    cmp("R11 follower keeps left data", s_brd, 8'h77);

    // R10 reset in the middle of a collision
    drv(1, 0, 12'h300, 0, 1, 0, 12'h300, 0); cyc();
    rst = 1'b1; cyc();
    cmp("R10 busy cleared by reset", m_bbusy, 1);
    cmp("R10 rdata cleared by reset", m_brd, 0);
    rst = 1'b0;
    idle();

    // R9 follower write inhibit
    sa_bin = 1'b0;
    drv(1, 1, 12'h010, 8'h99, 0, 0, 0, 0); cyc();
    sa_bin = 1'b1; sb_bin = 1'b0;
    drv(1, 0, 12'h010, 0, 1, 0, 12'h011, 0); cyc();
    cmp("R9 arbitrating instance stored write", m_ard, 8'h99);
    cmp("R9 follower write suppressed", s_ard, iv(12'h010));
    cmp("R9 follower reads under busy input", s_brd, iv(12'h011));
    sb_bin = 1'b1;
    idle();

    // random phase on four words
    for (int n = 0; n < 3000; n++) begin
      drv(($urandom % 4) != 0, ($urandom % 3) == 0, $urandom % 4, $urandom % 256,
          ($urandom % 4) != 0, ($urandom % 3) == 0, $urandom % 4, $urandom % 256);
      sa_bin = ($urandom % 4) != 0;
      sb_bin = ($urandom % 4) != 0;
      cyc();
    end
    finish_run();
  end

endmodule